// File: doc/BRIEF.md
# Branch Condition and Interrupt Sequencer

This block owns the program counter of a small 16-bit processor. It takes one decoded control-flow instruction at a time, decides from the arithmetic flags whether a conditional jump, call or return is taken, and computes the next PC. It also moves return addresses to and from a word-wide stack memory port, and tells the register file how the stack pointer changes. It accepts hardware interrupt requests, holds them while interrupts are disabled, and on entry pushes the PC and loads the handler address from a vector table in memory.

The decoder presents an instruction with `instr_valid_i` while `busy_o` is low. The block evaluates the instruction in that cycle. Jumps, calls and non-branching instructions finish within that single cycle. Returns, software interrupts and interrupt entry need extra cycles to read a word from memory, and `busy_o` stays high during those cycles. Stack-pointer updates appear on `sp_wr_o`/`sp_o` in the cycle of the matching memory access. Memory read data returns one cycle after the read request.

Top module: `branch_irq_seq`

## Requirements
- R1: After reset, `pc_o` is 0xFFF0, `ie_o` is 0, `busy_o` is 0 and no memory request is issued.
- R2: The condition code `cond_i` is decoded against `flags_i` (bit 0 zero Z, bit 1 carry C, bit 2 overflow O, bit 3 sign S) as follows: 0 Z, 1 !Z, 2 C, 3 !C, 4 S, 5 !S, 6 O, 7 !O, 8 !Z&!C, 9 Z|C, 10 (O==S)&!Z, 11 O==S, 12 O!=S, 13 (O!=S)|Z, 15 always. Code 14 is never taken.
- R3: A taken relative jump (`op_i`=1) sets PC to PC+2 plus twice the 7-bit signed `offset_i`. An untaken relative jump sets PC to PC+2.
- R4: A taken absolute jump (`op_i`=2) loads `dest_i`. An untaken one, and any non-branching instruction (`op_i`=0), advances PC by 2×`instr_len_i`.
- R5: A taken call (`op_i`=3) writes PC+2×`instr_len_i` to address `sp_i`−2, drives `sp_o`=`sp_i`−2 with `sp_wr_o`, and loads PC with `dest_i`, all in one cycle.
- R6: A taken return (`op_i`=4) reads the word at `sp_i` and drives `sp_o`=`sp_i`+2. On the next cycle it loads PC from the returned data.
- R7: An untaken call or return makes no memory access and no stack-pointer write, and it advances PC past the instruction.
- R8: A software interrupt (`op_i`=5) pushes PC+2×`instr_len_i` as a call does. It then reads the word at `vector_i`×2 (zero-extended) and loads PC from it.
- R9: STI (`op_i`=6) raises `ie_o` one cycle after the cycle in which it is accepted. CLI (`op_i`=7) clears `ie_o` at once and cancels an STI that is still waiting to take effect.
- R10: A request on `irq_i` stays latched until it is serviced. When `ie_o` is 1 and requests are pending, the lowest-numbered one is taken before any instruction. Entry pushes the current PC, clears `ie_o`, and loads PC from the word at index×2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_valid_i | input | 1 | Decoded instruction present |
| op_i | input | 3 | Operation class (0 other, 1 rel jump, 2 abs jump, 3 call, 4 return, 5 soft int, 6 STI, 7 CLI) |
| cond_i | input | 4 | Condition code |
| flags_i | input | 4 | Flags {S,O,C,Z} |
| offset_i | input | 7 | Signed relative word offset |
| vector_i | input | 7 | Software interrupt vector |
| instr_len_i | input | 2 | Instruction length in words |
| dest_i | input | 16 | Resolved destination operand |
| sp_i | input | 16 | Current stack pointer |
| irq_i | input | 8 | Hardware interrupt request pulses |
| mem_rdata_i | input | 16 | Stack/vector read data, one cycle after request |
| busy_o | output | 1 | Block cannot accept an instruction |
| pc_o | output | 16 | Program counter |
| ie_o | output | 1 | Global interrupt enable |
| sp_wr_o | output | 1 | Stack pointer update strobe |
| sp_o | output | 16 | New stack pointer value |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory write |
| mem_addr_o | output | 16 | Memory byte address |
| mem_wdata_o | output | 16 | Memory write data |

## Verification
The inline properties check five rules on every cycle. Every stack write lowers the stack pointer by exactly two and targets the new top. A PC load is always preceded by a memory read. Interrupt entry always leaves interrupts disabled. The enable only rises after a delayed STI. The pending grant is one-hot and picks the lowest pending request. Only the bench scenarios can show that the correct address is computed: the sweep covers all condition codes under every flag pattern and every relative offset, and further scenarios check the pushed return values, vector-table loads, and the order in which two latched requests are served.

// File: rtl/bsq_pkg.sv
package bsq_pkg;
  typedef enum logic [2:0] {
    OP_NONE = 3'd0, OP_JREL = 3'd1, OP_JABS = 3'd2, OP_CALL = 3'd3,
    OP_RET  = 3'd4, OP_INT  = 3'd5, OP_STI  = 3'd6, OP_CLI  = 3'd7
  } op_e;

  typedef enum logic [1:0] {ST_IDLE, ST_VEC, ST_LOAD} state_e;

  localparam int FL_Z = 0;
  localparam int FL_C = 1;
  localparam int FL_O = 2;
  localparam int FL_S = 3;
endpackage

// File: rtl/bsq_cond_eval.sv
module bsq_cond_eval
  import bsq_pkg::*;
(
  input  logic [3:0] cond_i,
  input  logic [3:0] flags_i,
  output logic       take_o
);
  logic z, c, o, s;
  assign z = flags_i[FL_Z];
  assign c = flags_i[FL_C];
  assign o = flags_i[FL_O];
  assign s = flags_i[FL_S];

  always_comb begin
    unique case (cond_i)
      4'h0: take_o = z;
      4'h1: take_o = !z;
      4'h2: take_o = c;
      4'h3: take_o = !c;
      4'h4: take_o = s;
      4'h5: take_o = !s;
      4'h6: take_o = o;
      4'h7: take_o = !o;
      4'h8: take_o = !z && !c;
      4'h9: take_o = z || c;
      4'hA: take_o = (o == s) && !z;
      4'hB: take_o = (o == s);
      4'hC: take_o = (o != s);
      4'hD: take_o = (o != s) || z;
      4'hE: take_o = 1'b0;
      default: take_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/bsq_irq_latch.sv
module bsq_irq_latch #(
  parameter int N_IRQ = 8,
  localparam int IDX_W = $clog2(N_IRQ)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_IRQ-1:0] req_i,
  input  logic             clr_en_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [N_IRQ-1:0] grant_o
);
  logic [N_IRQ-1:0] pend_q;

  always_comb begin
    grant_o = '0;
    idx_o   = '0;
    for (int i = N_IRQ - 1; i >= 0; i--) begin
      if (pend_q[i]) begin
        grant_o    = '0;
        grant_o[i] = 1'b1;
        idx_o      = IDX_W'(i);
      end
    end
  end

  assign any_o = |pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~(clr_en_i ? grant_o : '0)) | req_i;
  end

  AST_GRANT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_o)); // R10
  AST_GRANT_LOWEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o != '0) |-> (((grant_o - 1'b1) & pend_q) == '0)); // R10
  AST_PEND_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q != '0 && !clr_en_i) |=> (pend_q != '0)); // R10
endmodule

// File: rtl/branch_irq_seq.sv
module branch_irq_seq
  import bsq_pkg::*;
#(
  parameter int          W        = 16,
  parameter int          OFF_W    = 7,
  parameter int          VEC_W    = 7,
  parameter int          N_IRQ    = 8,
  parameter logic [15:0] RESET_PC = 16'hFFF0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             instr_valid_i,
  input  logic [2:0]       op_i,
  input  logic [3:0]       cond_i,
  input  logic [3:0]       flags_i,
  input  logic [OFF_W-1:0] offset_i,
  input  logic [VEC_W-1:0] vector_i,
  input  logic [1:0]       instr_len_i,
  input  logic [W-1:0]     dest_i,
  input  logic [W-1:0]     sp_i,
  input  logic [N_IRQ-1:0] irq_i,
  input  logic [W-1:0]     mem_rdata_i,
  output logic             busy_o,
  output logic [W-1:0]     pc_o,
  output logic             ie_o,
  output logic             sp_wr_o,
  output logic [W-1:0]     sp_o,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [W-1:0]     mem_addr_o,
  output logic [W-1:0]     mem_wdata_o
);
  localparam int IDX_W = $clog2(N_IRQ);

  state_e           state_q, state_d;
  logic [W-1:0]     pc_q, pc_d;
  logic             ie_q, ie_d, arm_q, arm_d;
  logic [VEC_W-1:0] vec_q, vec_d;

  logic             take;
  logic             irq_any, irq_take, accept;
  logic [IDX_W-1:0] irq_idx;
  logic [N_IRQ-1:0] irq_grant;
  logic [W-1:0]     pc_seq, pc_rel;
  op_e              op;

  assign op = op_e'(op_i);

  bsq_cond_eval u_cond (
    .cond_i (cond_i),
    .flags_i(flags_i),
    .take_o (take)
  );

  bsq_irq_latch #(.N_IRQ(N_IRQ)) u_irq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (irq_i),
    .clr_en_i(irq_take),
    .any_o   (irq_any),
    .idx_o   (irq_idx),
    .grant_o (irq_grant)
  );

  assign irq_take = (state_q == ST_IDLE) && ie_q && irq_any;
  assign accept   = instr_valid_i && (state_q == ST_IDLE) && !irq_take;
  assign busy_o   = (state_q != ST_IDLE) || irq_take;

  assign pc_seq = pc_q + (W'(instr_len_i) << 1);
  assign pc_rel = pc_q + W'(2) + {{(W-OFF_W-1){offset_i[OFF_W-1]}}, offset_i, 1'b0};

  always_comb begin
    state_d     = state_q;
    pc_d        = pc_q;
    vec_d       = vec_q;
    ie_d        = arm_q ? 1'b1 : ie_q;
    arm_d       = 1'b0;
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    sp_wr_o     = 1'b0;
    sp_o        = sp_i;
    unique case (state_q)
      ST_IDLE: begin
        if (irq_take) begin
          mem_req_o   = 1'b1;
          mem_we_o    = 1'b1;
          mem_addr_o  = sp_i - W'(2);
          mem_wdata_o = pc_q;
          sp_wr_o     = 1'b1;
          sp_o        = sp_i - W'(2);
          ie_d        = 1'b0;
          vec_d       = VEC_W'(irq_idx);
          state_d     = ST_VEC;
        end else if (accept) begin
          pc_d = pc_seq;
          unique case (op)
            OP_JREL: if (take) pc_d = pc_rel;
            OP_JABS: if (take) pc_d = dest_i;
            OP_CALL, OP_INT: begin
              if (take || op == OP_INT) begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = sp_i - W'(2);
                mem_wdata_o = pc_seq;
                sp_wr_o     = 1'b1;
                sp_o        = sp_i - W'(2);
                if (op == OP_CALL) begin
                  pc_d = dest_i;
                end else begin
                  vec_d   = vector_i;
                  state_d = ST_VEC;
                end
              end
            end
            OP_RET: begin
              if (take) begin
                mem_req_o  = 1'b1;
                mem_addr_o = sp_i;
                sp_wr_o    = 1'b1;
                sp_o       = sp_i + W'(2);
                state_d    = ST_LOAD;
              end
            end
            OP_STI: arm_d = 1'b1;
            OP_CLI: ie_d  = 1'b0;
            default: ;
          endcase
        end
      end
      ST_VEC: begin
        mem_req_o  = 1'b1;
        mem_addr_o = W'({vec_q, 1'b0});
        state_d    = ST_LOAD;
      end
      default: begin
        pc_d    = mem_rdata_i;
        state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pc_q    <= W'(RESET_PC);
      ie_q    <= 1'b0;
      arm_q   <= 1'b0;
      vec_q   <= '0;
    end else begin
      state_q <= state_d;
      pc_q    <= pc_d;
      ie_q    <= ie_d;
      arm_q   <= arm_d;
      vec_q   <= vec_d;
    end
  end

  assign pc_o = pc_q;
  assign ie_o = ie_q;

  AST_PUSH_MOVES_SP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (sp_wr_o && sp_o == mem_addr_o && sp_o == sp_i - W'(2))); // R5
  AST_LOAD_AFTER_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LOAD) |-> $past(mem_req_o && !mem_we_o)); // R6
  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !accept && !irq_take) |-> (!mem_req_o && !sp_wr_o)); // R7
  AST_STI_LATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ie_q) |-> $past(arm_q)); // R9
  AST_ENTRY_DISABLES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_take |=> !ie_o); // R10
endmodule

// File: tb/branch_irq_seq_test.sv
module branch_irq_seq_test;
  import bsq_pkg::*;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_valid = 1'b0;
  logic [2:0]  op = '0;
  logic [3:0]  cond = '0, flags = '0;
  logic [6:0]  offset = '0, vector = '0;
  logic [1:0]  len = 2'd1;
  logic [15:0] dest = '0;
  logic [15:0] sp_reg;
  logic [7:0]  irq = '0;
  logic [15:0] rdata;
  logic        busy, ie, sp_wr, mem_req, mem_we;
  logic [15:0] pc, sp_new, mem_addr, mem_wdata;
  logic [15:0] bmem [0:255];
  int          n_vec = 0, n_bad = 0;
  logic        done = 1'b0;
  logic [15:0] exp_pc, saved_pc;

  always #(CLK_PERIOD/2) clk = ~clk;

  branch_irq_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .instr_valid_i(instr_valid), .op_i(op),
    .cond_i(cond), .flags_i(flags), .offset_i(offset), .vector_i(vector),
    .instr_len_i(len), .dest_i(dest), .sp_i(sp_reg), .irq_i(irq),
    .mem_rdata_i(rdata), .busy_o(busy), .pc_o(pc), .ie_o(ie),
    .sp_wr_o(sp_wr), .sp_o(sp_new), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata)
  );

  always @(posedge clk) begin
    if (mem_req && mem_we) bmem[mem_addr[8:1]] <= mem_wdata;
    if (mem_req && !mem_we) rdata <= bmem[mem_addr[8:1]];
    if (sp_wr) sp_reg <= sp_new;
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic cond_ref(input logic [3:0] cc, input logic [3:0] f);
    logic z, c, o, s;
    z = f[0]; c = f[1]; o = f[2]; s = f[3];
    case (cc)
      4'd0: return z;            4'd1: return ~z;
      4'd2: return c;            4'd3: return ~c;
      4'd4: return s;            4'd5: return ~s;
      4'd6: return o;            4'd7: return ~o;
      4'd8: return ~(z | c);     4'd9: return z | c;
      4'd10: return ~(o ^ s) & ~z;
      4'd11: return ~(o ^ s);
      4'd12: return o ^ s;
      4'd13: return (o ^ s) | z;
      4'd14: return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  task automatic run(input op_e o, input logic [3:0] cc, input logic [3:0] f,
                     input logic [15:0] d, input logic [6:0] off,
                     input logic [6:0] v, input logic [1:0] l);
    @(negedge clk);
    op = o; cond = cc; flags = f; dest = d; offset = off; vector = v; len = l;
    instr_valid = 1'b1;
    @(negedge clk);
    instr_valid = 1'b0;
    while (busy) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) bmem[i] = 16'(i * 3);
    bmem[2] = 16'h2200; bmem[5] = 16'h2500; bmem[9] = 16'h0A00;
    sp_reg = 16'h0100;
    repeat (3) @(negedge clk);
    chk("R1 pc in reset", pc, 16'hFFF0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 pc", pc, 16'hFFF0);
    chk("R1 ie", {15'd0, ie}, 16'd0);
    chk("R1 busy", {15'd0, busy}, 16'd0);
    chk("R1 mem_req", {15'd0, mem_req}, 16'd0);

    // R4 plain advance and absolute jump
    run(OP_NONE, 4'hF, 4'h0, 16'h0, 7'd0, 7'd0, 2'd3);
    chk("R4 advance len3", pc, 16'hFFF6);
    run(OP_JABS, 4'hF, 4'h0, 16'h0200, 7'd0, 7'd0, 2'd2);
    chk("R4 abs taken", pc, 16'h0200);
    run(OP_JABS, 4'hE, 4'hF, 16'h0900, 7'd0, 7'd0, 2'd2);
    chk("R4 abs untaken len2", pc, 16'h0204);
    exp_pc = 16'h0204;

    // R2 full sweep
    for (int c = 0; c < 16; c++) begin
      for (int f = 0; f < 16; f++) begin
        logic [15:0] d;
        d = 16'h0400 + 16'(c * 32 + f * 2);
        run(OP_JABS, 4'(c), 4'(f), d, 7'd0, 7'd0, 2'd1);
        exp_pc = cond_ref(4'(c), 4'(f)) ? d : exp_pc + 16'd2;
        chk($sformatf("R2 cond=%0d flags=%0d", c, f), pc, exp_pc);
      end
    end

    // R3 relative sweep
    for (int k = 0; k < 128; k++) begin
      run(OP_JREL, 4'hF, 4'h0, 16'h0, 7'(k), 7'd0, 2'd1);
      exp_pc = exp_pc + 16'd2 + {{8{k[6]}}, 7'(k), 1'b0};
      chk($sformatf("R3 rel off=%0d", k), pc, exp_pc);
    end
    run(OP_JREL, 4'h0, 4'h0, 16'h0, 7'h3F, 7'd0, 2'd1);
    exp_pc = exp_pc + 16'd2;
    chk("R3 rel untaken", pc, exp_pc);

    // R5 call / R6 return
    run(OP_CALL, 4'hF, 4'h0, 16'h0300, 7'd0, 7'd0, 2'd2);
    chk("R5 call pc", pc, 16'h0300);
    chk("R5 call sp", sp_reg, 16'h00FE);
    chk("R5 call pushed", bmem[8'h7F], exp_pc + 16'd4);
    run(OP_RET, 4'hF, 4'h0, 16'h0, 7'd0, 7'd0, 2'd1);
    exp_pc = exp_pc + 16'd4;
    chk("R6 ret pc", pc, exp_pc);
    chk("R6 ret sp", sp_reg, 16'h0100);

    // R7 untaken call / ret
    bmem[8'h7F] = 16'hBEEF;
    run(OP_CALL, 4'h0, 4'h0, 16'h0700, 7'd0, 7'd0, 2'd2);
    exp_pc = exp_pc + 16'd4;
    chk("R7 call untaken pc", pc, exp_pc);
    chk("R7 call untaken sp", sp_reg, 16'h0100);
    chk("R7 call untaken stack", bmem[8'h7F], 16'hBEEF);
    run(OP_RET, 4'h1, 4'h1, 16'h0, 7'd0, 7'd0, 2'd1);
    exp_pc = exp_pc + 16'd2;
    chk("R7 ret untaken pc", pc, exp_pc);
    chk("R7 ret untaken sp", sp_reg, 16'h0100);

    // R8 software interrupt
    run(OP_INT, 4'h0, 4'h0, 16'h0, 7'd0, 7'd9, 2'd1);
    chk("R8 int pc", pc, 16'h0A00);
    chk("R8 int pushed", bmem[8'h7F], exp_pc + 16'd2);
    chk("R8 int sp", sp_reg, 16'h00FE);
    run(OP_RET, 4'hF, 4'h0, 16'h0, 7'd0, 7'd0, 2'd1);
    exp_pc = exp_pc + 16'd2;
    chk("R8 int return", pc, exp_pc);

    // R9 STI delay, CLI immediate
    run(OP_STI, 4'h0, 4'h0, 16'h0, 7'd0, 7'd0, 2'd1);
    exp_pc = exp_pc + 16'd2;
    chk("R9 ie not yet", {15'd0, ie}, 16'd0);
    @(negedge clk);
    chk("R9 ie after delay", {15'd0, ie}, 16'd1);
    run(OP_CLI, 4'h0, 4'h0, 16'h0, 7'd0, 7'd0, 2'd1);
    exp_pc = exp_pc + 16'd2;
    chk("R9 cli immediate", {15'd0, ie}, 16'd0);

    // R10 latched requests, lowest first
    @(negedge clk); irq = 8'h20;
    @(negedge clk); irq = 8'h00;
    @(negedge clk); irq = 8'h04;
    @(negedge clk); irq = 8'h00;
    repeat (3) @(negedge clk);
    chk("R10 held while disabled busy", {15'd0, busy}, 16'd0);
    chk("R10 held while disabled pc", pc, exp_pc);
    run(OP_STI, 4'h0, 4'h0, 16'h0, 7'd0, 7'd0, 2'd1);
    exp_pc = exp_pc + 16'd2;
    @(negedge clk);
    while (busy) @(negedge clk);
    chk("R10 first vector", pc, 16'h2200);
    chk("R10 pushed pc", bmem[8'h7F], exp_pc);
    chk("R10 ie cleared", {15'd0, ie}, 16'd0);
    chk("R10 sp", sp_reg, 16'h00FE);
    saved_pc = exp_pc;
    run(OP_RET, 4'hF, 4'h0, 16'h0, 7'd0, 7'd0, 2'd1);
    chk("R10 return", pc, saved_pc);
    run(OP_STI, 4'h0, 4'h0, 16'h0, 7'd0, 7'd0, 2'd1);
    @(negedge clk);
    while (busy) @(negedge clk);
    chk("R10 second vector", pc, 16'h2500);
    chk("R10 second pushed", bmem[8'h7F], saved_pc + 16'd2);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule